// File: doc/BRIEF.md
# Prioritized Latched Interrupt Controller

This block gathers interrupt requests from eight active-low external pins and seven internal peripheral lines and tells the processor which level should interrupt it. Every source carries a programmable 3-bit level, and every source chooses between supplying its own 8-bit vector and asking the processor to use an autovector derived from the level. External pins are latched on a falling edge into a pending bit that software can also set or clear. Internal lines are level requests that the peripheral holds until the controller pulses an acknowledge back to it.

The controller keeps the current processor level. A request is presented only when its level is strictly above that level. When the processor acknowledges a level, the controller serves the highest-ranked requester at that level. In the next cycle it returns a vector or an autovector indication, clears the served request, and loads a new processor level. In nesting mode the new level is the acknowledged one. Otherwise it is 7, which blocks further nesting. Configuration is through a small write/read register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every external control register reads 0x00, every external vector register reads 0x0F, every internal level register reads 0x00, the processor level `cpu_level_o` is 7 and no request is presented.
- R2: An external source whose control bits [7:6] are 01 sets its pending bit (bit 3 of its control register) when its pin is sampled high and then low on consecutive clocks. With [7:6] at 00 (off), 10 (port) or 11 (reserved) no pending bit is latched.
- R3: A write to an external control register loads its pending bit from bit 3 of the write data, so software can set or clear it.
- R4: A source with level 0 (control bits [2:0], or internal level register bits [2:0]) never requests, even while pending.
- R5: Among requesting sources the highest level wins. Ties are broken in the fixed order external 7 down to external 0, then internal bit 6 down to bit 0 (Timer 2, Timer 1, Timer 0, UART receive, UART transmit, I2C 2, I2C 1).
- R6: `irq_valid_o` is 1 and `irq_level_o` carries the winning level only when that level is strictly greater than `cpu_level_o`. Otherwise both read 0.
- R7: One clock after `ack_i`, `ack_done_o` is 1 for the served source. If its vector-mode bit is 1 (external control bit 5, internal level register bit 3), `ack_auto_o` is 0 and `ack_vec_o` holds the external vector register or the internal source's `int_vec_i` byte. If that bit is 0, `ack_auto_o` is 1 and `ack_vec_o` is 24 plus the level.
- R8: An acknowledge serves only the highest-ranked requester at `ack_level_i`. For an external source its pending bit is cleared. For an internal source bit j of `int_ack_o` pulses for one cycle.
- R9: On acknowledge `cpu_level_o` becomes `ack_level_i` when `nest_mode_i` is 1, and 7 when it is 0. Otherwise a `mask_we_i` write loads it.
- R10: An acknowledge with no requester at that level returns `ack_auto_o`=1 and `ack_vec_o`=24 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n_i | input | N_EXT | Active-low external interrupt pins |
| int_req_i | input | N_INT | Internal peripheral request lines, held until acknowledged |
| int_vec_i | input | N_INT*8 | Vector byte offered by each internal source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Register select: external control 0..7, external vector 8..15, internal level 16..22 |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Read data for the selected register |
| mask_we_i | input | 1 | Load the processor level |
| mask_wdata_i | input | 3 | New processor level |
| nest_mode_i | input | 1 | 1: acknowledged level becomes the mask; 0: mask becomes 7 |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| ack_level_i | input | 3 | Level being acknowledged |
| irq_valid_o | output | 1 | A request above the processor level exists |
| irq_level_o | output | 3 | Level of the presented request |
| cpu_level_o | output | 3 | Current processor level held by the controller |
| ack_done_o | output | 1 | Acknowledge answer valid |
| ack_auto_o | output | 1 | Answer is an autovector |
| ack_vec_o | output | 8 | Vector number answered |
| int_ack_o | output | N_INT | One-cycle acknowledge to the served internal source |

## Verification
A pending bit that is wrong inside the controller shows up at once, and in two ways. In the same cycle, `irq_level_o` changes, or a request that should pass the mask is missing. On the next acknowledge, the wrong source's vector appears on `ack_vec_o`, one clock after `ack_i`. A stale processor level shows as a request that is presented or withheld against the strict-greater rule right after an acknowledge. A broken tie-break shows as the wrong vector or the wrong `int_ack_o` bit on an acknowledge of a shared level. The bench rewrites every source's configuration many times at random and acknowledges the presented level each time, so each such fault reaches the ports within a few dozen cycles.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int LVL_W = 3;
    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] AUTOVEC_BASE = 8'd24;
    localparam logic [VEC_W-1:0] VEC_RESET    = 8'h0F;
    localparam logic [LVL_W-1:0] LVL_TOP      = 3'd7;

    typedef enum logic [1:0] {
        EXT_OFF  = 2'b00,
        EXT_ON   = 2'b01,
        EXT_PORT = 2'b10,
        EXT_RSVD = 2'b11
    } ext_mode_e;

    typedef struct packed {
        ext_mode_e        mode;
        logic             vsel;
        logic             pend;
        logic [LVL_W-1:0] lvl;
    } ext_cfg_t;

    function automatic logic [VEC_W-1:0] pack_ctl(ext_cfg_t c);
        return {c.mode, c.vsel, 1'b0, c.pend, c.lvl};
    endfunction

    function automatic logic [VEC_W-1:0] auto_vec(logic [LVL_W-1:0] l);
        return AUTOVEC_BASE + VEC_W'(l);
    endfunction

endpackage

// File: rtl/pic_ext_slot.sv
module pic_ext_slot
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_n_i,
    input  logic             wr_ctl_i,
    input  logic             wr_vec_i,
    input  logic [6:0]       ctl_data_i,
    input  logic [VEC_W-1:0] vec_data_i,
    input  logic             ack_clr_i,
    output ext_cfg_t         cfg_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             req_o
);
    ext_cfg_t         cfg_q;
    logic [VEC_W-1:0] vec_q;
    logic             pin_q;
    logic             fall;
    logic             enabled;

    assign enabled = (cfg_q.mode == EXT_ON);
    assign fall    = pin_q & ~pin_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: EXT_OFF, vsel: 1'b0, pend: 1'b0, lvl: '0};
            vec_q <= VEC_RESET;
            pin_q <= 1'b1;
        end else begin
            pin_q <= pin_n_i;
            if (wr_ctl_i) begin
                cfg_q.mode <= ext_mode_e'(ctl_data_i[6:5]);
                cfg_q.vsel <= ctl_data_i[4];
                cfg_q.pend <= ctl_data_i[3];
                cfg_q.lvl  <= ctl_data_i[2:0];
            end else if (enabled && fall) begin
                cfg_q.pend <= 1'b1;
            end else if (ack_clr_i) begin
                cfg_q.pend <= 1'b0;
            end
            if (wr_vec_i) vec_q <= vec_data_i;
        end
    end

    assign cfg_o = cfg_q;
    assign vec_o = vec_q;
    assign req_o = enabled && cfg_q.pend && (cfg_q.lvl != '0);

    p_edge_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_ctl_i && enabled && fall) |=> cfg_q.pend);

    p_sw_pend_r3: assert property (@(posedge clk) disable iff (rst)
        wr_ctl_i |=> (cfg_q.pend == $past(ctl_data_i[3])));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_clr_i && !wr_ctl_i && !(enabled && fall)) |=> !cfg_q.pend);

    p_lvl0_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lvl == '0) |-> !req_o);

endmodule

// File: rtl/pic_int_slot.sv
module pic_int_slot
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             wr_i,
    input  logic [LVL_W:0]   wdata_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             vsel_o,
    output logic             req_o
);
    logic [LVL_W-1:0] lvl_q;
    logic             vsel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            vsel_q <= 1'b0;
        end else if (wr_i) begin
            lvl_q  <= wdata_i[LVL_W-1:0];
            vsel_q <= wdata_i[LVL_W];
        end
    end

    assign lvl_o  = lvl_q;
    assign vsel_o = vsel_q;
    assign req_o  = req_i && (lvl_q != '0);

    p_int_lvl0_r4: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == '0) |-> !req_o);

endmodule

// File: rtl/pic_rank.sv
module pic_rank
    import pic_pkg::*;
#(
    parameter  int N  = 15,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]       req_i,
    input  logic [N*LVL_W-1:0] lvl_i,
    output logic               found_o,
    output logic [IW-1:0]      idx_o,
    output logic [LVL_W-1:0]   lvl_o
);
    // Ascending scan with >= lets the highest index win ties.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int s = 0; s < N; s++) begin
            if (req_i[s] && (lvl_i[s*LVL_W +: LVL_W] >= lvl_o)) begin
                found_o = 1'b1;
                idx_o   = IW'(s);
                lvl_o   = lvl_i[s*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter  int N_EXT  = 8,
    parameter  int N_INT  = 7,
    localparam int ADDR_W = $clog2(2*N_EXT + N_INT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_EXT-1:0]       ext_pin_n_i,
    input  logic [N_INT-1:0]       int_req_i,
    input  logic [N_INT*VEC_W-1:0] int_vec_i,
    input  logic                   cfg_we_i,
    input  logic [ADDR_W-1:0]      cfg_addr_i,
    input  logic [VEC_W-1:0]       cfg_wdata_i,
    output logic [VEC_W-1:0]       cfg_rdata_o,
    input  logic                   mask_we_i,
    input  logic [LVL_W-1:0]       mask_wdata_i,
    input  logic                   nest_mode_i,
    input  logic                   ack_i,
    input  logic [LVL_W-1:0]       ack_level_i,
    output logic                   irq_valid_o,
    output logic [LVL_W-1:0]       irq_level_o,
    output logic [LVL_W-1:0]       cpu_level_o,
    output logic                   ack_done_o,
    output logic                   ack_auto_o,
    output logic [VEC_W-1:0]       ack_vec_o,
    output logic [N_INT-1:0]       int_ack_o
);
    localparam int N_SRC = N_EXT + N_INT;
    localparam int IDX_W = $clog2(N_SRC);

    // Unified source numbering: internal j -> j, external i -> N_INT+i.
    logic [N_SRC-1:0]       src_req;
    logic [N_SRC*LVL_W-1:0] src_lvl;
    logic [N_SRC-1:0]       src_auto;
    logic [N_SRC*VEC_W-1:0] src_vec;
    logic [N_SRC-1:0]       match_req;

    ext_cfg_t         ext_cfg [N_EXT];
    logic [VEC_W-1:0] ext_vec [N_EXT];
    logic [LVL_W-1:0] int_lvl [N_INT];
    logic             int_vsel[N_INT];

    logic             best_found, ack_found;
    logic [IDX_W-1:0] best_idx, ack_idx;
    logic [LVL_W-1:0] best_lvl, ack_lvl_unused;

    logic [LVL_W-1:0] mask_q;
    logic             ack_done_q, ack_auto_q;
    logic [VEC_W-1:0] ack_vec_q;
    logic [N_INT-1:0] int_ack_q, int_ack_d;

    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_ext
            logic ack_clr;
            assign ack_clr = ack_i && ack_found && (ack_idx == IDX_W'(N_INT + gi));
            pic_ext_slot u_slot (
                .clk        (clk),
                .rst        (rst),
                .pin_n_i    (ext_pin_n_i[gi]),
                .wr_ctl_i   (cfg_we_i && (cfg_addr_i == ADDR_W'(gi))),
                .wr_vec_i   (cfg_we_i && (cfg_addr_i == ADDR_W'(N_EXT + gi))),
                .ctl_data_i ({cfg_wdata_i[7:5], cfg_wdata_i[3:0]}),
                .vec_data_i (cfg_wdata_i),
                .ack_clr_i  (ack_clr),
                .cfg_o      (ext_cfg[gi]),
                .vec_o      (ext_vec[gi]),
                .req_o      (src_req[N_INT + gi])
            );
            assign src_lvl[(N_INT+gi)*LVL_W +: LVL_W] = ext_cfg[gi].lvl;
            assign src_auto[N_INT + gi]               = ~ext_cfg[gi].vsel;
            assign src_vec[(N_INT+gi)*VEC_W +: VEC_W] = ext_vec[gi];
        end

        for (gi = 0; gi < N_INT; gi++) begin : g_int
            pic_int_slot u_slot (
                .clk     (clk),
                .rst     (rst),
                .req_i   (int_req_i[gi]),
                .wr_i    (cfg_we_i && (cfg_addr_i == ADDR_W'(2*N_EXT + gi))),
                .wdata_i (cfg_wdata_i[LVL_W:0]),
                .lvl_o   (int_lvl[gi]),
                .vsel_o  (int_vsel[gi]),
                .req_o   (src_req[gi])
            );
            assign src_lvl[gi*LVL_W +: LVL_W] = int_lvl[gi];
            assign src_auto[gi]               = ~int_vsel[gi];
            assign src_vec[gi*VEC_W +: VEC_W] = int_vec_i[gi*VEC_W +: VEC_W];
            assign int_ack_d[gi] = ack_i && ack_found && (ack_idx == IDX_W'(gi));
        end

        for (gi = 0; gi < N_SRC; gi++) begin : g_match
            assign match_req[gi] = src_req[gi] && (src_lvl[gi*LVL_W +: LVL_W] == ack_level_i);
        end
    endgenerate

    pic_rank #(.N(N_SRC)) u_rank_irq (
        .req_i   (src_req),
        .lvl_i   (src_lvl),
        .found_o (best_found),
        .idx_o   (best_idx),
        .lvl_o   (best_lvl)
    );

    pic_rank #(.N(N_SRC)) u_rank_ack (
        .req_i   (match_req),
        .lvl_i   (src_lvl),
        .found_o (ack_found),
        .idx_o   (ack_idx),
        .lvl_o   (ack_lvl_unused)
    );

    assign irq_valid_o = best_found && (best_lvl > mask_q);
    assign irq_level_o = irq_valid_o ? best_lvl : '0;
    assign cpu_level_o = mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= LVL_TOP;
            ack_done_q <= 1'b0;
            ack_auto_q <= 1'b0;
            ack_vec_q  <= '0;
            int_ack_q  <= '0;
        end else begin
            ack_done_q <= ack_i;
            int_ack_q  <= int_ack_d;
            if (ack_i) begin
                mask_q <= nest_mode_i ? ack_level_i : LVL_TOP;
                if (!ack_found) begin
                    ack_auto_q <= 1'b1;
                    ack_vec_q  <= AUTOVEC_BASE;
                end else if (src_auto[ack_idx]) begin
                    ack_auto_q <= 1'b1;
                    ack_vec_q  <= auto_vec(ack_level_i);
                end else begin
                    ack_auto_q <= 1'b0;
                    ack_vec_q  <= src_vec[ack_idx*VEC_W +: VEC_W];
                end
            end else if (mask_we_i) begin
                mask_q <= mask_wdata_i;
            end
        end
    end

    assign ack_done_o = ack_done_q;
    assign ack_auto_o = ack_auto_q;
    assign ack_vec_o  = ack_vec_q;
    assign int_ack_o  = int_ack_q;

    always_comb begin
        cfg_rdata_o = '0;
        for (int i = 0; i < N_EXT; i++) begin
            if (cfg_addr_i == ADDR_W'(i))         cfg_rdata_o = pack_ctl(ext_cfg[i]);
            if (cfg_addr_i == ADDR_W'(N_EXT + i)) cfg_rdata_o = ext_vec[i];
        end
        for (int j = 0; j < N_INT; j++) begin
            if (cfg_addr_i == ADDR_W'(2*N_EXT + j))
                cfg_rdata_o = {{(VEC_W-LVL_W-1){1'b0}}, int_vsel[j], int_lvl[j]};
        end
    end

    p_above_mask_r6: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> (irq_level_o > mask_q));

    p_winner_real_r5: assert property (@(posedge clk) disable iff (rst)
        best_found |-> src_req[best_idx]);

    p_ack_answer_r7: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> ack_done_o);

    p_mask_nest_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_i && nest_mode_i) |=> (cpu_level_o == $past(ack_level_i)));

    p_mask_flat_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !nest_mode_i) |=> (cpu_level_o == LVL_TOP));

    p_one_int_ack_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(int_ack_o));

    p_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !ack_found) |=> (ack_auto_o && (ack_vec_o == AUTOVEC_BASE) && (int_ack_o == '0)));

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ext_pin_n = 8'hFF;
    logic [6:0]  int_req = '0;
    logic [55:0] int_vec = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        mask_we = 1'b0;
    logic [2:0]  mask_wdata = '0;
    logic        nest_mode = 1'b0;
    logic        ack = 1'b0;
    logic [2:0]  ack_level = '0;
    logic        irq_valid;
    logic [2:0]  irq_level;
    logic [2:0]  cpu_level;
    logic        ack_done, ack_auto;
    logic [7:0]  ack_vec;
    logic [6:0]  int_ack;

    always #2 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_pin_n_i(ext_pin_n), .int_req_i(int_req),
        .int_vec_i(int_vec), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .mask_we_i(mask_we),
        .mask_wdata_i(mask_wdata), .nest_mode_i(nest_mode), .ack_i(ack),
        .ack_level_i(ack_level), .irq_valid_o(irq_valid), .irq_level_o(irq_level),
        .cpu_level_o(cpu_level), .ack_done_o(ack_done), .ack_auto_o(ack_auto),
        .ack_vec_o(ack_vec), .int_ack_o(int_ack)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench shadow of the programmed state.
    bit [1:0] s_ic [8];
    bit       s_av [8];
    bit       s_pd [8];
    bit [2:0] s_lv [8];
    bit [7:0] s_vec[8];
    bit [2:0] s_il [7];
    bit       s_im [7];
    bit [7:0] s_ivec[7];
    bit [6:0] s_req;
    bit [2:0] s_mask;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_req(int s);
        if (s >= 7) return (s_ic[s-7] == 2'b01) && s_pd[s-7] && (s_lv[s-7] != 0);
        return s_req[s] && (s_il[s] != 0);
    endfunction

    function automatic int m_lvl(int s);
        if (s >= 7) return int'(s_lv[s-7]);
        return int'(s_il[s]);
    endfunction

    // want < 0: best overall; otherwise highest-ranked at that exact level
    function automatic int m_pick(int want);
        int w = -1;
        int bl = 0;
        for (int s = 0; s < 15; s++) begin
            if (m_req(s)) begin
                if ((want < 0) ? (m_lvl(s) >= bl) : (m_lvl(s) == want)) begin
                    w = s;
                    bl = m_lvl(s);
                end
            end
        end
        return w;
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        cfg_addr = 5'(addr);
        #1 data = int'(cfg_rdata);
    endtask

    task automatic wr_ext(input int i, input int ic, input bit av, input bit pd, input int lv);
        s_ic[i] = 2'(ic); s_av[i] = av; s_pd[i] = pd; s_lv[i] = 3'(lv);
        wr(i, {ic[1:0], av, 1'b0, pd, lv[2:0]});
    endtask

    task automatic wr_int(input int j, input bit im, input int lv);
        s_im[j] = im; s_il[j] = 3'(lv);
        wr(16 + j, {4'b0, im, lv[2:0]});
    endtask

    task automatic set_mask(input int m);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = 3'(m);
        @(negedge clk);
        mask_we = 1'b0;
        s_mask = 3'(m);
    endtask

    task automatic check_irq(input string tag);
        int w, bl;
        bit ev;
        w  = m_pick(-1);
        bl = (w >= 0) ? m_lvl(w) : 0;
        ev = (bl > int'(s_mask));
        #1;
        chk(irq_valid == ev, {tag, " R6 valid"}, irq_valid, ev);
        chk(int'(irq_level) == (ev ? bl : 0), {tag, " R5 level"}, irq_level, ev ? bl : 0);
    endtask

    task automatic do_ack(input int lvl, input bit nest);
        int w, ev, rdv;
        bit ea;
        w = m_pick(lvl);
        if (w < 0) begin ea = 1; ev = 24; end
        else if (w >= 7) begin ea = !s_av[w-7]; ev = s_av[w-7] ? int'(s_vec[w-7]) : 24 + lvl; end
        else begin ea = !s_im[w]; ev = s_im[w] ? int'(s_ivec[w]) : 24 + lvl; end
        @(negedge clk);
        ack = 1'b1; ack_level = 3'(lvl); nest_mode = nest;
        @(negedge clk);
        ack = 1'b0;
        chk(ack_done == 1'b1, "R7 ack_done", ack_done, 1);
        chk(ack_auto == ea, (w < 0) ? "R10 auto" : "R7 auto", ack_auto, ea);
        chk(int'(ack_vec) == ev, (w < 0) ? "R10 vector" : "R7 vector", ack_vec, ev);
        chk(int_ack == ((w >= 0 && w < 7) ? 7'(1 << w) : 7'd0), "R8 int_ack", int_ack,
            (w >= 0 && w < 7) ? (1 << w) : 0);
        s_mask = nest ? 3'(lvl) : 3'd7;
        chk(cpu_level == s_mask, "R9 level", cpu_level, s_mask);
        if (w >= 7) begin
            s_pd[w-7] = 0;
            rd(w - 7, rdv);
            chk(rdv[3] == 1'b0, "R8 pend cleared", rdv, 0);
        end else if (w >= 0) begin
            s_req[w] = 0;
            int_req[w] = 1'b0;
        end
    endtask

    task automatic pulse_pin(input int i);
        @(negedge clk); ext_pin_n[i] = 1'b0;
        @(negedge clk); ext_pin_n[i] = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd4711));
        for (int j = 0; j < 7; j++) begin
            s_ivec[j] = 8'($urandom);
            int_vec[j*8 +: 8] = s_ivec[j];
        end
        for (int i = 0; i < 8; i++) begin
            s_ic[i] = 0; s_av[i] = 0; s_pd[i] = 0; s_lv[i] = 0; s_vec[i] = 8'h0F;
        end
        for (int j = 0; j < 7; j++) begin s_il[j] = 0; s_im[j] = 0; end
        s_req = 0; s_mask = 7;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, v);  chk(v == 8'h00, "R1 ext ctl", v, 8'h00);
        rd(9, v);  chk(v == 8'h0F, "R1 ext vector", v, 8'h0F);
        rd(20, v); chk(v == 8'h00, "R1 int level", v, 0);
        chk(cpu_level == 3'd7, "R1 cpu level", cpu_level, 7);
        chk(irq_valid == 1'b0, "R1 no request", irq_valid, 0);

        // R2 falling-edge latch only when enabled
        wr_ext(3, 1, 0, 0, 5);
        pulse_pin(3);
        rd(3, v); chk(v == 8'h4D, "R2 latched", v, 8'h4D);
        s_pd[3] = 1;
        wr_ext(2, 0, 0, 0, 5);
        pulse_pin(2);
        rd(2, v); chk(v == 8'h05, "R2 disabled no latch", v, 8'h05);
        wr_ext(1, 2, 0, 0, 5);
        pulse_pin(1);
        rd(1, v); chk(v == 8'h85, "R2 port no latch", v, 8'h85);
        wr_ext(0, 3, 0, 0, 5);
        pulse_pin(0);
        rd(0, v); chk(v == 8'hC5, "R2 reserved no latch", v, 8'hC5);

        // R3 software pending control
        wr_ext(3, 1, 0, 0, 5);
        rd(3, v); chk(v == 8'h45, "R3 clear", v, 8'h45);
        wr_ext(3, 1, 0, 1, 5);
        rd(3, v); chk(v == 8'h4D, "R3 set", v, 8'h4D);

        // R6 strict comparison against the mask
        check_irq("mask7");
        set_mask(4); check_irq("mask4");
        set_mask(5); check_irq("mask5 strict");
        set_mask(4);

        // R4 level 0 never requests
        wr_ext(6, 1, 0, 1, 0);
        check_irq("R4 lvl0");
        chk(irq_level == 3'd5, "R4 level0 ignored", irq_level, 5);
        do_ack(5, 1'b0);
        check_irq("after flat ack");

        // R10 spurious acknowledge
        set_mask(0);
        do_ack(3, 1'b1);

        // R5 tie between external and internal at the same level
        set_mask(0);
        wr_ext(5, 1, 1, 1, 2);
        wr(13, 8'hA5); s_vec[5] = 8'hA5;
        wr_int(6, 1'b1, 2);
        @(negedge clk); s_req[6] = 1; int_req[6] = 1'b1;
        check_irq("R5 tie");
        do_ack(2, 1'b1);
        do_ack(2, 1'b1);

        // Random configurations
        for (int it = 0; it < 60; it++) begin
            for (int i = 0; i < 8; i++) begin
                int ic;
                ic = ($urandom % 4 == 0) ? int'($urandom % 4) : 1;
                wr_ext(i, ic, 1'($urandom), 1'($urandom), int'($urandom % 8));
                s_vec[i] = 8'($urandom);
                wr(8 + i, s_vec[i]);
            end
            for (int j = 0; j < 7; j++) wr_int(j, 1'($urandom), int'($urandom % 8));
            @(negedge clk);
            s_req = 7'($urandom);
            int_req = s_req;
            set_mask(int'($urandom % 4));
            check_irq("rand");
            if (irq_valid) do_ack(int'(irq_level), 1'($urandom));
            else do_ack(int'($urandom % 8), 1'($urandom));
            check_irq("rand post-ack");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule